// File: doc/BRIEF.md
# Overcurrent Fault Qualifier

This block decides when a converter's output current has been too high for long enough to count as a fault. It receives one digitised current-sense code per switching period. Codes that arrive during a programmable blanking window are thrown away, because the switching edge rings in that window. Every other code is compared with a programmable limit. A code above the limit cuts the high-side on-time short for the rest of that period. A run of consecutive over-limit codes is counted, and the fault is declared once the run is longer than a programmable allowance.

When a fault is declared, a selectable response is applied. The block can keep running and go on limiting cycle by cycle. It can shut down and stay latched off until it is re-enabled. Or it can shut down for a programmable hiccup delay and then restart. A sticky fault flag records that the fault happened until software clears it or the block is disabled. The limit, blanking length, allowance, response and hiccup delay are held in registers elsewhere and arrive as static inputs. The reset value of the limit register (the code for 4.5 A) is set outside this block.

Top module: `ocp_qualifier`

## Requirements
- R1: A sample that is accepted is a violation only when its code is strictly greater than `cfg_limit_i`. A code equal to the limit is in range.
- R2: With `cfg_blank_i` = N, every sample in the cycle of a `cyc_start_i` strobe and in the following N-1 clock cycles is discarded. With N = 0, nothing is discarded.
- R3: The violation count goes up by one on each accepted violation and drops to zero on any accepted in-range sample, so only an unbroken run counts.
- R4: A fault is declared on the (`cfg_allow_i`+1)-th consecutive accepted violation. `fault_o` rises on the clock edge after that sample.
- R5: `trunc_o` goes high on the clock edge after an accepted violation. It stays high until the edge after the next `cyc_start_i` strobe that carries no violation of its own.
- R6: Response code 0 keeps the block running and never asserts `shutdown_o`. Codes 1 and 3 assert `shutdown_o` from the edge after the declaration, and it stays high until `enable_i` goes low.
- R7: Response code 2 holds `shutdown_o` high for `cfg_hiccup_i`+1 cycles. The block then resumes running with the violation count at zero.
- R8: `fault_o` stays set until a cycle with `flt_clear_i` high or `enable_i` low. A declaration in the same cycle as `flt_clear_i` wins.
- R9: Samples are ignored while `enable_i` is low, while `shutdown_o` is high, and in the first cycle after `enable_i` rises.
- R10: While `rst_ni` is low, `fault_o`, `trunc_o` and `shutdown_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Converter enable; low clears state and re-arms |
| cyc_start_i | input | 1 | Switching-period start strobe |
| smp_valid_i | input | 1 | Current sample valid |
| smp_data_i | input | DW | Current sample code |
| cfg_limit_i | input | DW | Current-limit threshold code |
| cfg_blank_i | input | BW | Blanking length in clock ticks |
| cfg_allow_i | input | CW | Consecutive violations tolerated |
| cfg_action_i | input | 2 | Fault response: 0 limit, 1 latch, 2 retry, 3 latch |
| cfg_hiccup_i | input | HW | Hiccup delay in clock ticks |
| flt_clear_i | input | 1 | Clears the sticky fault flag |
| fault_o | output | 1 | Sticky fault flag |
| trunc_o | output | 1 | Terminate on-time for the current period |
| shutdown_o | output | 1 | Power stage off |

## Verification
The assertions check the following on every cycle:
- no sample is accepted during blanking or shutdown;
- the count steps up by one or falls to zero;
- a latched shutdown holds;
- a hiccup that has run out returns to running;
- the fault flag stays set unless it is cleared or the block is disabled.

Other properties depend on how the configuration and the stimulus line up, and only the bench's scenarios show them. These are the exact sample on which the fault is declared for a given allowance, the length of the hiccup window, equality with the limit, a blanking length of zero, and a clear that coincides with a declaration. The bench follows them with a behavioural model that is compared on every clock.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_RUN    = 2'd1,
    ST_LATCH  = 2'd2,
    ST_HICCUP = 2'd3
  } ocp_state_e;

  typedef enum logic [1:0] {
    ACT_LIMIT = 2'd0,
    ACT_LATCH = 2'd1,
    ACT_RETRY = 2'd2,
    ACT_RSVD  = 2'd3
  } ocp_action_e;
endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cyc_start_i,
  input  logic [BW-1:0] blank_len_i,
  output logic          blank_o
);
  logic [BW-1:0] cnt_q;
  logic          len_zero;

  assign len_zero = (blank_len_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (cyc_start_i)
      cnt_q <= len_zero ? '0 : blank_len_i - BW'(1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - BW'(1);
  end

  // strobe cycle itself is the first blanked tick
  assign blank_o = cyc_start_i ? !len_zero : (cnt_q != '0);

  AST_BLANK_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_i && (blank_len_i > BW'(1)) |=> blank_o || cyc_start_i); // R2
endmodule

// File: rtl/ocp_viol_counter.sv
module ocp_viol_counter #(
  parameter int DW = 10,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_data_i,
  input  logic [DW-1:0] limit_i,
  input  logic [CW-1:0] allow_i,
  input  logic          blank_i,
  input  logic          run_i,
  input  logic          clear_i,
  output logic          acc_o,
  output logic          viol_o,
  output logic          declare_o
);
  localparam int CNT_W = CW + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign acc_o     = smp_valid_i && !blank_i && run_i;
  assign viol_o    = acc_o && (smp_data_i > limit_i);
  assign cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
  assign declare_o = viol_o && (cnt_inc > {1'b0, allow_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (clear_i)
      cnt_q <= '0;
    else if (acc_o)
      cnt_q <= viol_o ? cnt_inc : '0;
  end

  AST_BLANK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |-> !acc_o); // R2
  AST_RUN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !declare_o); // R9
  AST_CNT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o && !viol_o |=> cnt_q == '0); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o && !clear_i && (cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R3
endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl
  import ocp_pkg::*;
#(
  parameter int HW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          flt_clear_i,
  input  logic          cyc_start_i,
  input  logic [1:0]    action_i,
  input  logic [HW-1:0] hiccup_i,
  input  logic          viol_i,
  input  logic          declare_i,
  output logic          run_o,
  output logic          cnt_clr_o,
  output logic          fault_o,
  output logic          trunc_o,
  output logic          shutdown_o
);
  ocp_state_e    state_q;
  ocp_action_e   act;
  logic [HW-1:0] hic_q;
  logic          fault_q;
  logic          trunc_q;
  logic          shut_req;

  assign act      = ocp_action_e'(action_i);
  assign shut_req = declare_i && (act != ACT_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      hic_q   <= '0;
      fault_q <= 1'b0;
      trunc_q <= 1'b0;
    end else if (!enable_i) begin
      state_q <= ST_OFF;
      hic_q   <= '0;
      fault_q <= 1'b0;
      trunc_q <= 1'b0;
    end else begin
      if (declare_i)        fault_q <= 1'b1;
      else if (flt_clear_i) fault_q <= 1'b0;
      unique case (state_q)
        ST_OFF: state_q <= ST_RUN;
        ST_RUN: begin
          if (shut_req) begin
            state_q <= (act == ACT_RETRY) ? ST_HICCUP : ST_LATCH;
            hic_q   <= hiccup_i;
            trunc_q <= 1'b0;
          end else if (viol_i) begin
            trunc_q <= 1'b1;
          end else if (cyc_start_i) begin
            trunc_q <= 1'b0;
          end
        end
        ST_LATCH: state_q <= ST_LATCH;
        ST_HICCUP: begin
          if (hic_q == '0) state_q <= ST_RUN;
          else             hic_q   <= hic_q - HW'(1);
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assign run_o      = (state_q == ST_RUN);
  assign cnt_clr_o  = !enable_i || shut_req;
  assign fault_o    = fault_q;
  assign trunc_o    = trunc_q;
  assign shutdown_o = (state_q == ST_LATCH) || (state_q == ST_HICCUP);

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCH) && enable_i |=> state_q == ST_LATCH); // R6
  AST_HICCUP_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HICCUP) && (hic_q == '0) && enable_i |=> run_o); // R7
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !flt_clear_i && enable_i |=> fault_o); // R8
  AST_DISABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !fault_o && !shutdown_o && !trunc_o); // R8
  AST_TRUNC_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_i && !viol_i |=> !trunc_o); // R5
  AST_LIMIT_NO_SHDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && declare_i && (action_i == 2'd0) |=> !shutdown_o); // R6
endmodule

// File: rtl/ocp_qualifier.sv
module ocp_qualifier #(
  parameter int DW = 10,
  parameter int BW = 8,
  parameter int CW = 4,
  parameter int HW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          cyc_start_i,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_data_i,
  input  logic [DW-1:0] cfg_limit_i,
  input  logic [BW-1:0] cfg_blank_i,
  input  logic [CW-1:0] cfg_allow_i,
  input  logic [1:0]    cfg_action_i,
  input  logic [HW-1:0] cfg_hiccup_i,
  input  logic          flt_clear_i,
  output logic          fault_o,
  output logic          trunc_o,
  output logic          shutdown_o
);
  logic blank;
  logic run;
  logic cnt_clr;
  logic acc;
  logic viol;
  logic declare;

  ocp_blank_timer #(.BW(BW)) u_blank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cyc_start_i (cyc_start_i),
    .blank_len_i (cfg_blank_i),
    .blank_o     (blank)
  );

  ocp_viol_counter #(.DW(DW), .CW(CW)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_valid_i (smp_valid_i),
    .smp_data_i  (smp_data_i),
    .limit_i     (cfg_limit_i),
    .allow_i     (cfg_allow_i),
    .blank_i     (blank),
    .run_i       (run),
    .clear_i     (cnt_clr),
    .acc_o       (acc),
    .viol_o      (viol),
    .declare_o   (declare)
  );

  ocp_fault_ctrl #(.HW(HW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .flt_clear_i (flt_clear_i),
    .cyc_start_i (cyc_start_i),
    .action_i    (cfg_action_i),
    .hiccup_i    (cfg_hiccup_i),
    .viol_i      (viol),
    .declare_i   (declare),
    .run_o       (run),
    .cnt_clr_o   (cnt_clr),
    .fault_o     (fault_o),
    .trunc_o     (trunc_o),
    .shutdown_o  (shutdown_o)
  );

  AST_SHDN_NO_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> !acc); // R9
  AST_VIOL_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol |-> smp_data_i > cfg_limit_i); // R1
endmodule

// File: tb/ocp_qualifier_test.sv
module ocp_qualifier_test;
  localparam int DW = 10, BW = 8, CW = 4, HW = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enable = 1'b0, cyc = 1'b0, vld = 1'b0, clr = 1'b0;
  logic [DW-1:0] dat = '0;
  logic [DW-1:0] lim = 10'd500;
  logic [BW-1:0] blk_len = 8'd3;
  logic [CW-1:0] allow = 4'd2;
  logic [1:0]    act = 2'd0;
  logic [HW-1:0] hic_len = 12'd5;
  logic fault, trunc, shdn;

  int checks = 0, errors = 0;
  string tag = "R10";
  bit done = 0;

  always #5 clk = ~clk;

  ocp_qualifier #(.DW(DW), .BW(BW), .CW(CW), .HW(HW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable), .cyc_start_i(cyc),
    .smp_valid_i(vld), .smp_data_i(dat), .cfg_limit_i(lim), .cfg_blank_i(blk_len),
    .cfg_allow_i(allow), .cfg_action_i(act), .cfg_hiccup_i(hic_len),
    .flt_clear_i(clr), .fault_o(fault), .trunc_o(trunc), .shutdown_o(shdn)
  );

  // behavioural model: 0 off, 1 run, 2 latched, 3 hiccup
  int m_state, m_cnt, m_blank, m_hic;
  bit m_fault, m_trunc, m_blk, m_acc, m_viol, m_decl;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_cnt = 0; m_blank = 0; m_hic = 0; m_fault = 0; m_trunc = 0;
    end else begin
      m_blk  = cyc ? (blk_len != 0) : (m_blank > 0);
      m_acc  = vld && !m_blk && enable && (m_state == 1);
      m_viol = m_acc && (int'(dat) > int'(lim));
      m_decl = m_viol && (m_cnt + 1 > int'(allow));
      if (cyc) m_blank = (blk_len > 0) ? int'(blk_len) - 1 : 0;
      else if (m_blank > 0) m_blank--;
      if (!enable) begin
        m_state = 0; m_cnt = 0; m_fault = 0; m_trunc = 0; m_hic = 0;
      end else begin
        if (m_decl) m_fault = 1; else if (clr) m_fault = 0;
        case (m_state)
          0: m_state = 1;
          1: if (m_decl && act != 0) begin
               m_state = (act == 2) ? 3 : 2; m_hic = int'(hic_len); m_cnt = 0; m_trunc = 0;
             end else begin
               if (m_acc) m_cnt = m_viol ? ((m_cnt < 31) ? m_cnt + 1 : 31) : 0;
               if (m_viol) m_trunc = 1; else if (cyc) m_trunc = 0;
             end
          3: if (m_hic == 0) m_state = 1; else m_hic--;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string t, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", t, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check(tag, "fault_o", fault, m_fault);
    check(tag, "trunc_o", trunc, m_trunc);
    check(tag, "shutdown_o", shdn, m_state == 2 || m_state == 3);
  end

  task automatic tick(bit s, bit v, int d);
    cyc = s; vld = v; dat = DW'(d);
    @(negedge clk);
  endtask

  task automatic period(int d, int off);
    for (int k = 0; k < 8; k++) tick(k == 0, k == off, (k == off) ? d : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "fault_o in reset", fault, 1'b0);
    check("R10", "shutdown_o in reset", shdn, 1'b0);
    check("R10", "trunc_o in reset", trunc, 1'b0);
    rst_ni = 1'b1;
    tag = "R9"; enable = 1'b1;
    tick(0, 1, 900); tick(0, 0, 0);
    check("R9", "sample in first enabled cycle ignored", trunc, 1'b0);
    tag = "R1";
    period(500, 4);
    check("R1", "equal code not a violation", trunc, 1'b0);
    period(501, 4);
    check("R1", "code above limit truncates", trunc, 1'b1);
    tag = "R5";
    period(100, 4);
    check("R5", "trunc cleared by strobe", trunc, 1'b0);
    tag = "R2";
    period(900, 1); period(900, 2);
    check("R2", "blanked samples ignored", trunc, 1'b0);
    period(900, 3);
    check("R2", "first sample after window accepted", trunc, 1'b1);
    period(100, 4);
    blk_len = 8'd0; period(900, 0);
    check("R2", "zero blanking accepts strobe sample", trunc, 1'b1);
    blk_len = 8'd3;
    tag = "R3";
    period(100, 4); period(900, 4); period(900, 4); period(100, 4);
    period(900, 4); period(900, 4);
    check("R3", "broken run no fault", fault, 1'b0);
    tag = "R4";
    period(900, 4);
    check("R4", "fault on third violation", fault, 1'b1);
    check("R6", "action 0 no shutdown", shdn, 1'b0);
    tag = "R8";
    period(100, 4);
    check("R8", "fault sticky", fault, 1'b1);
    clr = 1'b1; tick(0, 0, 0); clr = 1'b0; tick(0, 0, 0);
    check("R8", "fault cleared by write", fault, 1'b0);
    clr = 1'b1; period(900, 4); clr = 1'b0;
    tag = "R6"; act = 2'd1; allow = 4'd1;
    period(100, 4); period(900, 4); period(900, 4);
    check("R6", "latched shutdown", shdn, 1'b1);
    tag = "R9";
    period(100, 4); period(900, 4); period(900, 4);
    check("R9", "still latched while samples arrive", shdn, 1'b1);
    enable = 1'b0; tick(0, 0, 0);
    check("R8", "disable clears fault", fault, 1'b0);
    check("R6", "disable releases latch", shdn, 1'b0);
    enable = 1'b1; tick(0, 0, 0);
    tag = "R6"; act = 2'd3; allow = 4'd0;
    period(900, 4);
    check("R6", "code 3 latches", shdn, 1'b1);
    enable = 1'b0; tick(0, 0, 0); enable = 1'b1; tick(0, 0, 0);
    tag = "R7"; act = 2'd2; allow = 4'd2;
    period(900, 4); period(900, 4);
    tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0); tick(0, 0, 0); tick(0, 1, 900);
    begin
      int n = 0;
      while (shdn && n < 50) begin n++; tick(0, 0, 0); end
      checks++;
      if (n != int'(hic_len) + 1) begin
        errors++;
        $display("FAIL R7 hiccup length: got %0d expected %0d", n, int'(hic_len) + 1);
      end
    end
    period(900, 4); period(900, 4);
    check("R7", "count restarted after hiccup", shdn, 1'b0);
    period(900, 4);
    check("R7", "retry again after fresh run", shdn, 1'b1);
    repeat (10) tick(0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule